// File: doc/BRIEF.md
# Simultaneous Multichannel ADC Reader

This block reads one sample from each of sixteen signal converters and one cold-junction converter, all tied to a single conversion event. It drives a free-running master clock and a shared sync pulse to a bank of serial sigma-delta converters. When the bank raises its ready line, the block produces 24 serial clock pulses and shifts every converter's data line into its own 24-bit register, most significant bit first, all lanes in parallel.

Once all words are captured, one shared multiplier walks through the channels one per cycle. For each channel it adds a signed offset, scales by an unsigned gain and saturates the result. Software loads the correction coefficients through a narrow write port. The cold-junction word is used only on the first capture after reset and on every `CJC_DECIM`-th capture after that. On the other captures its corrected value holds.

A one-cycle done strobe marks the moment the complete corrected set is valid. A ready edge that arrives while a capture is still being read or corrected is ignored, and it sets a sticky overrun flag.

Top module: `simul_adc_reader`

## Requirements
- R1: `adc_mclk` is low after reset and toggles every `MCLK_HALF` clock cycles without pause (default 2, so 20 level changes in any 40 consecutive cycles).
- R2: `adc_sync` is high in the clock cycle after any cycle in which `conv_start` is high, and low otherwise.
- R3: A rising edge on `adc_rdy` while idle starts a read of exactly 24 `adc_sclk` pulses. Each pulse is low for `SCLK_HALF` cycles, then high for `SCLK_HALF` cycles, and `adc_sclk` idles low. Each lane of `adc_sdo` is sampled at the edge where `adc_sclk` rises, and the first bit sampled is the MSB of the word.
- R4: The corrected value of a channel is floor(((raw + offset) * gain) / 2^23). Here raw and offset are signed 24-bit two's complement values and gain is an unsigned Q1.23 value.
- R5: A corrected value above 0x7FFFFF is clamped to 0x7FFFFF, and one below -2^23 is clamped to 0x800000.
- R6: A write with `cfg_we` high stores `cfg_wdata` for channel `cfg_chan`. `cfg_sel`=0 selects the offset and `cfg_sel`=1 selects the gain. Channels 0 to 15 are signal lanes and channel 16 is the cold-junction lane. Writes to channels above 16 change nothing. After reset every offset is 0 and every gain is 0x800000 (unity).
- R7: The cold-junction result (bits 407:384 of `smp_data`) is updated only on the first capture after reset and on every `CJC_DECIM`-th capture after that (default 4). On all other captures it keeps its previous value. `cjc_fresh` is high together with `smp_done` exactly on the captures that update it.
- R8: `smp_done` is high for one cycle per capture. In that cycle `smp_data` holds all corrected results, with channel c in bits [24c+23:24c]. These bits then hold until the next capture's results.
- R9: A rising edge on `adc_rdy` while a read or correction is in progress does not restart or extend the read. It sets `overrun`, which stays high until reset.
- R10: In reset, `smp_data` is zero and `smp_done`, `cjc_fresh`, `overrun`, `adc_sclk`, `adc_sync` and `adc_mclk` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_start | input | 1 | Request for a common conversion event |
| adc_rdy | input | 1 | Ready indication from the converter bank; its rising edge starts a read |
| adc_sdo | input | 17 | Serial data lines; bit 16 is the cold-junction converter |
| adc_sync | output | 1 | Shared sync pulse to all converters |
| adc_sclk | output | 1 | Shared serial clock |
| adc_mclk | output | 1 | Free-running converter master clock |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sel | input | 1 | 0 selects offset, 1 selects gain |
| cfg_chan | input | 5 | Channel index of the write |
| cfg_wdata | input | 24 | Coefficient value |
| smp_data | output | 408 | Corrected samples, channel c at bits [24c+23:24c] |
| smp_done | output | 1 | One-cycle strobe: all corrected samples valid |
| cjc_fresh | output | 1 | High with `smp_done` when the cold-junction result was updated |
| overrun | output | 1 | Sticky: a ready edge arrived during a capture |

## Verification
A table of eight stimulus rows drives every channel through a different combination of raw word, offset and gain. The rows cover the identity gain, fractional gains on negative sums (which separate floor rounding from truncation toward zero), positive and negative saturation, a near-double gain that overflows, and zero gain. Because each lane gets a distinct raw value and gain, a swapped lane, a reversed bit order or a shared coefficient shows up as a mismatch.

Directed runs then cover the rest. They count serial clock pulses and high time, count master clock toggles, and check that a sync pulse follows its request. They follow the cold-junction value across captures to confirm it holds between decimation points. A write to an out-of-range channel must leave every result unchanged. A second ready edge injected mid-read must raise the sticky overrun flag without disturbing the captured words.

// File: rtl/adcr_pkg.sv
package adcr_pkg;
  localparam int SMP_W   = 24;
  localparam int N_SIG   = 16;
  localparam int N_CH    = N_SIG + 1;
  localparam int CJC_IDX = N_SIG;
  localparam int CHW     = $clog2(N_CH);
  localparam int BITW    = $clog2(SMP_W);

  localparam logic [SMP_W-1:0] GAIN_UNITY = {1'b1, {(SMP_W-1){1'b0}}};

  typedef logic signed [SMP_W-1:0] smp_t;
  typedef logic [SMP_W-1:0]        gain_t;
  typedef logic [N_CH-1:0][SMP_W-1:0] bank_t;

  typedef enum logic [1:0] {RX_IDLE, RX_LOW, RX_HIGH} rx_state_e;

  // Offset add, Q1.23 gain scale with floor, clamp to the sample range.
  function automatic smp_t corr_fn(smp_t raw, smp_t off, gain_t gain);
    logic signed [SMP_W:0]     sum;
    logic signed [2*SMP_W+1:0] prod;
    logic signed [SMP_W+2:0]   shr;
    logic signed [SMP_W+2:0]   hi;
    logic signed [SMP_W+2:0]   lo;
    hi   = {4'b0000, {(SMP_W-1){1'b1}}};
    lo   = {4'b1111, {(SMP_W-1){1'b0}}};
    sum  = (SMP_W+1)'(raw) + (SMP_W+1)'(off);
    prod = sum * $signed({1'b0, gain});
    shr  = prod[2*SMP_W+1:SMP_W-1];
    if (shr > hi)      return {1'b0, {(SMP_W-1){1'b1}}};
    else if (shr < lo) return {1'b1, {(SMP_W-1){1'b0}}};
    else               return shr[SMP_W-1:0];
  endfunction
endpackage

// File: rtl/adcr_serial_rx.sv
module adcr_serial_rx
  import adcr_pkg::*;
#(
  parameter int SCLK_HALF = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rdy_in,
  input  logic            accept,
  input  logic [N_CH-1:0] sdo,
  output logic            sclk,
  output logic            rx_busy,
  output logic            words_done,
  output logic            rdy_lost,
  output bank_t           words
);
  localparam int PW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam logic [PW-1:0]   PH_LAST  = PW'(SCLK_HALF - 1);
  localparam logic [BITW-1:0] BIT_LAST = BITW'(SMP_W - 1);

  rx_state_e       st;
  logic [PW-1:0]   ph;
  logic [BITW-1:0] nbit;
  logic            rdy_q;
  logic            rdy_rise;
  logic            start_rd;
  logic            sample_en;

  assign rdy_rise  = rdy_in & ~rdy_q;
  assign start_rd  = rdy_rise & (st == RX_IDLE) & accept;
  assign rdy_lost  = rdy_rise & ~start_rd;
  assign sample_en = (st == RX_LOW) && (ph == PH_LAST);
  assign rx_busy   = (st != RX_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= RX_IDLE;
      ph         <= '0;
      nbit       <= '0;
      sclk       <= 1'b0;
      rdy_q      <= 1'b0;
      words_done <= 1'b0;
    end else begin
      rdy_q      <= rdy_in;
      words_done <= 1'b0;
      unique case (st)
        RX_IDLE: begin
          if (start_rd) begin
            st   <= RX_LOW;
            ph   <= '0;
            nbit <= '0;
          end
        end
        RX_LOW: begin
          if (ph == PH_LAST) begin
            sclk <= 1'b1;
            ph   <= '0;
            st   <= RX_HIGH;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        RX_HIGH: begin
          if (ph == PH_LAST) begin
            sclk <= 1'b0;
            ph   <= '0;
            if (nbit == BIT_LAST) begin
              st         <= RX_IDLE;
              words_done <= 1'b1;
            end else begin
              nbit <= nbit + 1'b1;
              st   <= RX_LOW;
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)         words[g] <= '0;
      else if (sample_en) words[g] <= {words[g][SMP_W-2:0], sdo[g]};
    end
  end

  // R3: serial clock only while a read is active
  p_sclk_in_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> rx_busy);
  // R3: bit counter never passes the word length
  p_bitcnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy |-> (nbit <= BIT_LAST));
  // R9: a lost ready edge does not move the read back to its first bit
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_lost && rx_busy && !(st == RX_HIGH && ph == PH_LAST)) |=> $stable(nbit));
endmodule

// File: rtl/adcr_coef_bank.sv
module adcr_coef_bank
  import adcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             sel,
  input  logic [CHW-1:0]   chan,
  input  logic [SMP_W-1:0] wdata,
  output bank_t            offs,
  output bank_t            gains
);
  for (genvar g = 0; g < N_CH; g++) begin : g_coef
    logic hit;
    assign hit = we && (chan == CHW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        offs[g]  <= '0;
        gains[g] <= GAIN_UNITY;
      end else if (hit) begin
        if (sel) gains[g] <= wdata;
        else     offs[g]  <= wdata;
      end
    end
  end

  // R6: an out-of-range channel write leaves every coefficient alone
  p_cfg_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (chan > CHW'(N_CH - 1))) |=> ($stable(offs) && $stable(gains)));
endmodule

// File: rtl/adcr_corr.sv
module adcr_corr
  import adcr_pkg::*;
#(
  parameter int CJC_DECIM = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  bank_t words,
  input  bank_t offs,
  input  bank_t gains,
  output bank_t res,
  output logic  done,
  output logic  fresh,
  output logic  busy
);
  localparam int DW = (CJC_DECIM > 1) ? $clog2(CJC_DECIM) : 1;
  localparam logic [DW-1:0]  D_LAST  = DW'(CJC_DECIM - 1);
  localparam logic [CHW-1:0] CH_LAST = CHW'(N_CH - 1);
  localparam logic [CHW-1:0] CH_CJC  = CHW'(CJC_IDX);

  logic [CHW-1:0] ch;
  logic [DW-1:0]  dcnt;
  logic           take_cjc;
  logic           wr_en;
  smp_t           cur;

  assign wr_en = busy && ((ch != CH_CJC) || take_cjc);
  assign cur   = corr_fn(words[ch], offs[ch], gains[ch]);
  assign fresh = done & take_cjc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      ch       <= '0;
      dcnt     <= '0;
      take_cjc <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy     <= 1'b1;
        ch       <= '0;
        take_cjc <= (dcnt == '0);
        dcnt     <= (dcnt == D_LAST) ? '0 : dcnt + 1'b1;
      end else if (busy) begin
        if (ch == CH_LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          ch <= ch + 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_res
    always_ff @(posedge clk) begin
      if (!rst_n)                             res[g] <= '0;
      else if (wr_en && (ch == CHW'(g)))      res[g] <= cur;
    end
  end

  // R8: done lasts exactly one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: results stay put between captures
  p_res_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(res));
  // R7: a skipped cold-junction turn leaves its result unchanged
  p_cjc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !take_cjc) |=> $stable(res[CJC_IDX]));
endmodule

// File: rtl/simul_adc_reader.sv
module simul_adc_reader
  import adcr_pkg::*;
#(
  parameter int SCLK_HALF = 2,
  parameter int MCLK_HALF = 2,
  parameter int CJC_DECIM = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  conv_start,
  input  logic                  adc_rdy,
  input  logic [N_CH-1:0]       adc_sdo,
  output logic                  adc_sync,
  output logic                  adc_sclk,
  output logic                  adc_mclk,
  input  logic                  cfg_we,
  input  logic                  cfg_sel,
  input  logic [CHW-1:0]        cfg_chan,
  input  logic [SMP_W-1:0]      cfg_wdata,
  output logic [N_CH*SMP_W-1:0] smp_data,
  output logic                  smp_done,
  output logic                  cjc_fresh,
  output logic                  overrun
);
  localparam int MW = (MCLK_HALF > 1) ? $clog2(MCLK_HALF) : 1;
  localparam logic [MW-1:0] M_LAST = MW'(MCLK_HALF - 1);

  logic          rx_busy;
  logic          words_done;
  logic          rdy_lost;
  logic          corr_busy;
  logic          accept;
  bank_t         words;
  bank_t         offs;
  bank_t         gains;
  bank_t         res;
  logic [MW-1:0] mcnt;

  assign accept   = ~corr_busy & ~words_done;
  assign smp_data = res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcnt     <= '0;
      adc_mclk <= 1'b0;
      adc_sync <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      adc_sync <= conv_start;
      overrun  <= overrun | rdy_lost;
      if (mcnt == M_LAST) begin
        mcnt     <= '0;
        adc_mclk <= ~adc_mclk;
      end else begin
        mcnt <= mcnt + 1'b1;
      end
    end
  end

  adcr_serial_rx #(.SCLK_HALF(SCLK_HALF)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rdy_in     (adc_rdy),
    .accept     (accept),
    .sdo        (adc_sdo),
    .sclk       (adc_sclk),
    .rx_busy    (rx_busy),
    .words_done (words_done),
    .rdy_lost   (rdy_lost),
    .words      (words)
  );

  adcr_coef_bank u_coef (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .chan  (cfg_chan),
    .wdata (cfg_wdata),
    .offs  (offs),
    .gains (gains)
  );

  adcr_corr #(.CJC_DECIM(CJC_DECIM)) u_corr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (words_done),
    .words (words),
    .offs  (offs),
    .gains (gains),
    .res   (res),
    .done  (smp_done),
    .fresh (cjc_fresh),
    .busy  (corr_busy)
  );

  // R1: master clock level only moves at the end of a half period
  p_mclk_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mcnt != M_LAST) |=> $stable(adc_mclk));
  // R2: sync follows its request one cycle later
  p_sync_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> adc_sync);
  // R9: overrun is sticky
  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R7: fresh cold-junction flag only with the done strobe
  p_fresh_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cjc_fresh |-> smp_done);
  // R8: reading and correcting never overlap
  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_busy && corr_busy));
endmodule

// File: tb/simul_adc_reader_bench.sv
module simul_adc_reader_bench;
  localparam int NCH   = 17;
  localparam int SW    = 24;
  localparam int SHALF = 2;
  localparam int MHALF = 2;
  localparam int DECIM = 4;

  localparam logic [23:0] T_RAW  [8] = '{24'h123456, 24'hF00000, 24'h7FFF00, 24'h800000,
                                         24'h3FFFFF, 24'hABCDEF, 24'h000003, 24'h5A5A5A};
  localparam logic [23:0] T_OFF  [8] = '{24'h000000, 24'h001000, 24'h000200, 24'hFFFFF0,
                                         24'h000001, 24'h0F0F0F, 24'hFFFFFD, 24'hA5A5A5};
  localparam logic [23:0] T_GAIN [8] = '{24'h800000, 24'h400000, 24'h800000, 24'h800000,
                                         24'hFFFFFF, 24'h000000, 24'hC00000, 24'h600000};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              conv_start = 1'b0;
  logic              adc_rdy = 1'b0;
  logic [NCH-1:0]    adc_sdo;
  logic              adc_sync, adc_sclk, adc_mclk;
  logic              cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [4:0]        cfg_chan = '0;
  logic [SW-1:0]     cfg_wdata = '0;
  logic [NCH*SW-1:0] smp_data;
  logic              smp_done, cjc_fresh, overrun;

  int checks = 0;
  int fails  = 0;
  int caps   = 0;

  logic [23:0] stub_w [NCH];
  int          stub_idx = 23;
  logic [23:0] m_off  [NCH];
  logic [23:0] m_gain [NCH];
  logic [23:0] cjc_held = '0;
  int          mon_rises = 0, mon_highs = 0;
  logic        mon_prev = 1'b0;

  always #2 clk = ~clk;

  simul_adc_reader #(.SCLK_HALF(SHALF), .MCLK_HALF(MHALF), .CJC_DECIM(DECIM)) u_simul_adc_reader (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .adc_rdy(adc_rdy), .adc_sdo(adc_sdo),
    .adc_sync(adc_sync), .adc_sclk(adc_sclk), .adc_mclk(adc_mclk),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_chan(cfg_chan), .cfg_wdata(cfg_wdata),
    .smp_data(smp_data), .smp_done(smp_done), .cjc_fresh(cjc_fresh), .overrun(overrun)
  );

  // Converter stub: next bit presented on each falling serial clock edge
  for (genvar c = 0; c < NCH; c++) begin : g_stub
    assign adc_sdo[c] = stub_w[c][stub_idx];
  end
  always @(negedge adc_sclk) if (stub_idx > 0) stub_idx--;

  always @(negedge clk) begin
    if (adc_sclk) mon_highs++;
    if (adc_sclk && !mon_prev) mon_rises++;
    mon_prev = adc_sclk;
  end

  function automatic logic [23:0] model(logic [23:0] raw, logic [23:0] off, logic [23:0] gain);
    longint s, p, q;
    s = longint'($signed(raw)) + longint'($signed(off));
    p = s * longint'({40'd0, gain});
    q = p >>> 23;
    if (q > 64'sd8388607) q = 64'sd8388607;
    else if (q < -64'sd8388608) q = -64'sd8388608;
    return q[23:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_coef(input logic sel, input int ch, input logic [23:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_chan = 5'(ch); cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    if (ch < NCH) begin
      if (sel) m_gain[ch] = val; else m_off[ch] = val;
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Run one capture with the words in stub_w and check all results
  task automatic capture(input bit glitch);
    int n;
    bit fresh_exp;
    logic [NCH*SW-1:0] snap;
    @(negedge clk);
    stub_idx = 23; mon_rises = 0; mon_highs = 0;
    adc_rdy = 1'b1;
    if (glitch) begin
      repeat (10) @(negedge clk);
      adc_rdy = 1'b0;
      @(negedge clk);
      adc_rdy = 1'b1;
    end
    n = 0;
    do begin @(negedge clk); n++; end while (!smp_done && n < 3000);
    if (!smp_done) begin
      chk("R8 done timeout", 32'(smp_done), 32'd1);
      return;
    end
    fresh_exp = (caps % DECIM) == 0;
    caps++;
    for (int c = 0; c < NCH - 1; c++)
      chk($sformatf("R4/R5 ch%0d", c), 32'(smp_data[c*SW +: SW]), 32'(model(stub_w[c], m_off[c], m_gain[c])));
    if (fresh_exp) cjc_held = model(stub_w[16], m_off[16], m_gain[16]);
    chk("R7 cjc value", 32'(smp_data[16*SW +: SW]), 32'(cjc_held));
    chk("R7 cjc_fresh", 32'(cjc_fresh), 32'(fresh_exp));
    chk("R3 sclk pulses", 32'(mon_rises), 32'd24);
    chk("R3 sclk high time", 32'(mon_highs), 32'(24 * SHALF));
    snap = smp_data;
    @(negedge clk);
    chk("R8 done one cycle", 32'(smp_done), 32'd0);
    chk("R8 data hold", 32'(smp_data == snap), 32'd1);
    adc_rdy = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int tog;
    logic prev;
    for (int c = 0; c < NCH; c++) begin
      m_off[c] = '0; m_gain[c] = 24'h800000; stub_w[c] = '0;
    end
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 smp_data", 32'(smp_data == '0), 32'd1);
    chk("R10 smp_done", 32'(smp_done), 32'd0);
    chk("R10 cjc_fresh", 32'(cjc_fresh), 32'd0);
    chk("R10 overrun", 32'(overrun), 32'd0);
    chk("R10 sclk", 32'(adc_sclk), 32'd0);
    chk("R10 sync", 32'(adc_sync), 32'd0);
    chk("R10 mclk", 32'(adc_mclk), 32'd0);
    rst_n = 1'b1;

    // R1: master clock toggles every MHALF cycles
    tog = 0; prev = adc_mclk;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (adc_mclk != prev) tog++;
      prev = adc_mclk;
    end
    chk("R1 mclk toggles", 32'(tog), 32'(40 / MHALF));

    // R2: sync pulse follows request
    @(negedge clk); conv_start = 1'b1;
    @(negedge clk); conv_start = 1'b0;
    chk("R2 sync high", 32'(adc_sync), 32'd1);
    @(negedge clk);
    chk("R2 sync low", 32'(adc_sync), 32'd0);

    // Table of vectors (R4, R5, R6, R7)
    for (int r = 0; r < 8; r++) begin
      for (int c = 0; c < NCH; c++) begin
        wr_coef(1'b0, c, T_OFF[r] ^ 24'(c * 3));
        wr_coef(1'b1, c, T_GAIN[r] ^ 24'(c << 4));
        stub_w[c] = T_RAW[r] ^ 24'(c);
      end
      capture(1'b0);
    end

    // R6: writes above channel 16 change nothing
    wr_coef(1'b1, 20, 24'h000000);
    wr_coef(1'b0, 17, 24'h7FFFFF);
    wr_coef(1'b1, 31, 24'h123456);
    for (int c = 0; c < NCH; c++) stub_w[c] = 24'h654321 ^ 24'(c << 8);
    capture(1'b0);
    chk("R9 no spurious overrun", 32'(overrun), 32'd0);

    // R9: second ready edge mid-read is ignored and latched
    for (int c = 0; c < NCH; c++) stub_w[c] = 24'h9ABCDE ^ 24'(c * 7);
    capture(1'b1);
    chk("R9 overrun set", 32'(overrun), 32'd1);
    for (int c = 0; c < NCH; c++) stub_w[c] = 24'h0F1E2D + 24'(c);
    capture(1'b0);
    chk("R9 overrun sticky", 32'(overrun), 32'd1);

    finish_run();
  end
endmodule